// File: doc/BRIEF.md
# Six-Pin General-Purpose I/O Port with Weak Pulldowns

This block is a six-pin bidirectional port that sits on a small synchronous register bus inside a microcontroller. Software sets a per-pin direction, writes an output value into a data latch, and reads back a port value. For a pin set as an output, that value is the latch. For a pin set as an input, it is the synchronized level on the pin. For each pin the block hands a drive value and an output enable to the pad wrapper. It also hands over a pulldown enable, which the wrapper applies as a weak pulldown.

Pulldowns are governed by three things. The first is a per-pin inhibit register that can be written but not read back. The second is the pin's direction. The third is a static, chip-wide option input that switches every pulldown off. The bus carries single-beat register accesses, not a data stream, so it has no valid/ready handshake. A write strobe takes effect at the clock edge where it is sampled. A read strobe loads the read data register at that same edge, and the value holds until the next read strobe.

Top module: `gpio6_port`

## Requirements
- R1: After reset the data latch, the direction register and the inhibit register are all zero. So `pad_oe` = 0, `pad_out` = 0 and, with `opt_pd_off` = 0, `pad_pd_en` = 6'h3F; `bus_rdata` = 0.
- R2: A write to address 0 (port data) loads `bus_wdata[5:0]` into the data latch whatever the direction bits are. `pad_out` shows the new value after that edge.
- R3: Address 1 (direction, 1 = output) can be written and read back. `pad_oe` follows it after the write edge. Read bits 7:6 are always zero.
- R4: A read of address 0 returns the data latch in every bit whose direction bit is 1.
- R5: A read of address 0 returns the pin level in every bit whose direction bit is 0, through a two-flop synchronizer. Suppose a pin changes before edge E1. Reads strobed at E1 and E2 return the old level, and a read strobed at E3 returns the new one.
- R6: Address 2 (pulldown inhibit, bit i for pin i, 1 = inhibit) can only be written. Reading it returns zero.
- R7: With `opt_pd_off` = 0, `pad_pd_en[i]` is 1 exactly when inhibit bit i is 0 and direction bit i is 0.
- R8: With `opt_pd_off` = 1, all of `pad_pd_en` is 0, whatever the inhibit and direction bits are.
- R9: `bus_rdata` is loaded only at an edge where `bus_rd` = 1 and holds otherwise. A read and a write to the same address in the same cycle return the value from before the write.
- R10: Address 3 is unused. Writes to it change no register, and reads of it return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| opt_pd_off | input | 1 | Static option: 1 turns every pulldown off |
| pin_in | input | 6 | Pin levels from the pad wrapper |
| pad_out | output | 6 | Drive value per pin |
| pad_oe | output | 6 | Output enable per pin |
| pad_pd_en | output | 6 | Weak pulldown enable per pin |

## Verification
A register write and a register read can land in the same cycle on the same address. The read must then see the state from before the write. The bench raises both strobes at one edge on the direction register. It expects the old direction in `bus_rdata`, and the new one both in `pad_oe` and in a following read. A second collision sets a pin level change against the synchronizer delay: reads strobed one, two and three edges after the change must give old, old and new.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_INH  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio6_regfile.sv
module gpio6_regfile
  import gpio6_pkg::*;
#(
  parameter int PIN_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PIN_W-1:0]  wdata,
  output logic [PIN_W-1:0]  latch_q,
  output logic [PIN_W-1:0]  dir_q,
  output logic [PIN_W-1:0]  inh_q
);
  logic wr_data, wr_dir, wr_inh;

  always_comb begin
    wr_data = wr_en && (addr == SEL_DATA);
    wr_dir  = wr_en && (addr == SEL_DIR);
    wr_inh  = wr_en && (addr == SEL_INH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      inh_q   <= '0;
    end else begin
      if (wr_data) latch_q <= wdata;
      if (wr_dir)  dir_q   <= wdata;
      if (wr_inh)  inh_q   <= wdata;
    end
  end

  // R10
  unused_addr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SEL_NONE) |=> ($stable(latch_q) && $stable(dir_q) && $stable(inh_q)));
endmodule

// File: rtl/gpio6_insync.sv
module gpio6_insync #(
  parameter int PIN_W  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pin_in,
  output logic [PIN_W-1:0] pin_sync
);
  for (genvar i = 0; i < PIN_W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], pin_in[i]};
    end
    assign pin_sync[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/gpio6_readback.sv
module gpio6_readback
  import gpio6_pkg::*;
#(
  parameter int PIN_W = 6,
  parameter int BUS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PIN_W-1:0]  latch_q,
  input  logic [PIN_W-1:0]  dir_q,
  input  logic [PIN_W-1:0]  pin_sync,
  output logic [BUS_W-1:0]  rdata
);
  localparam int PAD_W = BUS_W - PIN_W;

  logic [PIN_W-1:0] port_view;
  logic [PIN_W-1:0] sel_val;

  for (genvar i = 0; i < PIN_W; i++) begin : g_mux
    assign port_view[i] = dir_q[i] ? latch_q[i] : pin_sync[i];
  end

  always_comb begin
    unique case (addr)
      SEL_DATA: sel_val = port_view;
      SEL_DIR:  sel_val = dir_q;
      default:  sel_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= {{PAD_W{1'b0}}, sel_val};
  end

  // R6
  inh_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == SEL_INH) |=> (rdata == '0));
  // R3
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[BUS_W-1:PIN_W] == '0);
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/gpio6_pulldown.sv
module gpio6_pulldown #(
  parameter int PIN_W = 6
) (
  input  logic             opt_off,
  input  logic [PIN_W-1:0] inh_q,
  input  logic [PIN_W-1:0] dir_q,
  output logic [PIN_W-1:0] pd_en
);
  for (genvar i = 0; i < PIN_W; i++) begin : g_pd
    assign pd_en[i] = !opt_off && !inh_q[i] && !dir_q[i];
  end
endmodule

// File: rtl/gpio6_port.sv
module gpio6_port
  import gpio6_pkg::*;
#(
  parameter int PIN_W = 6,
  parameter int BUS_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              opt_pd_off,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pad_out,
  output logic [PIN_W-1:0]  pad_oe,
  output logic [PIN_W-1:0]  pad_pd_en
);
  logic [PIN_W-1:0] latch_q, dir_q, inh_q, pin_sync;
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[BUS_W-1:PIN_W];

  gpio6_regfile #(.PIN_W(PIN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata[PIN_W-1:0]),
    .latch_q(latch_q), .dir_q(dir_q), .inh_q(inh_q)
  );

  gpio6_insync #(.PIN_W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sync(pin_sync)
  );

  gpio6_readback #(.PIN_W(PIN_W), .BUS_W(BUS_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .addr(bus_addr),
    .latch_q(latch_q), .dir_q(dir_q), .pin_sync(pin_sync), .rdata(bus_rdata)
  );

  gpio6_pulldown #(.PIN_W(PIN_W)) u_pd (
    .opt_off(opt_pd_off), .inh_q(inh_q), .dir_q(dir_q), .pd_en(pad_pd_en)
  );

  assign pad_out = latch_q;
  assign pad_oe  = dir_q;

  // R2
  data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == SEL_DATA) |=> (pad_out == $past(bus_wdata[PIN_W-1:0])));
  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == SEL_DIR) |=> (pad_oe == $past(bus_wdata[PIN_W-1:0])));
  // R7
  no_pd_on_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pd_en & pad_oe) == '0);
  // R8
  opt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opt_pd_off |-> (pad_pd_en == '0));
endmodule

// File: tb/gpio6_port_tb.sv
module gpio6_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       opt_pd_off = 1'b0;
  logic [5:0] pin_in = '0;
  logic [5:0] pad_out, pad_oe, pad_pd_en;

  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  gpio6_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .opt_pd_off(opt_pd_off),
    .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pd_en(pad_pd_en)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1; bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 pad_oe", {2'b0, pad_oe}, 8'h00);
    check("R1 pad_out", {2'b0, pad_out}, 8'h00);
    check("R1 pad_pd_en", {2'b0, pad_pd_en}, 8'h3F);
    check("R1 rdata", bus_rdata, 8'h00);
    bus_read(2'd1, v); check("R1 dir read", v, 8'h00);
  endtask

  task automatic t_data_and_input();
    logic [7:0] v;
    bus_write(2'd0, 8'hEA);
    check("R2 latch while input", {2'b0, pad_out}, 8'h2A);
    pin_in = 6'h15; repeat (4) @(posedge clk);
    bus_read(2'd0, v); check("R5 input reads pins", v, 8'h15);
  endtask

  task automatic t_sync_latency();
    logic [7:0] v;
    @(negedge clk); pin_in = 6'h0C;
    bus_addr = 2'd0; bus_rd = 1'b1;
    @(posedge clk); #1; v = bus_rdata; check("R5 strobe E1 old", v, 8'h15);
    @(posedge clk); #1; v = bus_rdata; check("R5 strobe E2 old", v, 8'h15);
    @(posedge clk); #1; v = bus_rdata; check("R5 strobe E3 new", v, 8'h0C);
    bus_rd = 1'b0;
    pin_in = 6'h15; repeat (4) @(posedge clk);
  endtask

  task automatic t_direction();
    logic [7:0] v;
    bus_write(2'd1, 8'h0F);
    check("R3 pad_oe", {2'b0, pad_oe}, 8'h0F);
    bus_read(2'd1, v); check("R3 dir read", v, 8'h0F);
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, v); check("R3 upper bits zero", v, 8'h3F);
    bus_read(2'd0, v); check("R4 outputs read latch", v, 8'h2A);
    bus_write(2'd1, 8'h07);
    bus_read(2'd0, v); check("R4 R5 mixed", v, 8'h12);
  endtask

  task automatic t_pulldown();
    logic [7:0] v;
    bus_write(2'd1, 8'h00);
    bus_write(2'd2, 8'h3F);
    bus_read(2'd2, v); check("R6 inhibit reads zero", v, 8'h00);
    check("R7 all inhibited", {2'b0, pad_pd_en}, 8'h00);
    bus_write(2'd2, 8'h05);
    bus_write(2'd1, 8'h02);
    check("R7 mixed", {2'b0, pad_pd_en}, 8'h38);
    @(negedge clk); opt_pd_off = 1'b1; #1;
    check("R8 option off", {2'b0, pad_pd_en}, 8'h00);
    @(negedge clk); opt_pd_off = 1'b0; #1;
    check("R8 option back on", {2'b0, pad_pd_en}, 8'h38);
  endtask

  task automatic t_unused_addr();
    logic [7:0] v;
    bus_write(2'd3, 8'hFF);
    bus_read(2'd1, v); check("R10 dir unchanged", v, 8'h02);
    check("R10 latch unchanged", {2'b0, pad_out}, 8'h2A);
    check("R10 inhibit unchanged", {2'b0, pad_pd_en}, 8'h38);
    bus_read(2'd3, v); check("R10 reads zero", v, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    @(negedge clk); bus_addr = 2'd1; bus_wdata = 8'h11; bus_wr = 1'b1; bus_rd = 1'b1;
    @(posedge clk); #1; bus_wr = 1'b0; bus_rd = 1'b0;
    check("R9 read sees old", bus_rdata, 8'h02);
    check("R9 write took effect", {2'b0, pad_oe}, 8'h11);
    repeat (3) @(posedge clk); #1;
    check("R9 rdata holds", bus_rdata, 8'h02);
    bus_read(2'd1, v); check("R9 next read new", v, 8'h11);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_data_and_input();
    t_sync_latency();
    t_direction();
    t_pulldown();
    t_unused_addr();
    t_collision();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule